// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory with 2048 bytes, split into eight blocks of 256 bytes. It works in the system clock domain. It takes SCL and SDA samples that are already synchronised, and it drives a single pull-low enable for an open-drain SDA pad. The block finds bus START and STOP conditions and counts bits. It receives the control byte and the word address, and it answers each byte with an acknowledge slot.

Behind it sits a plain synchronous memory port. A read strobe returns data one cycle later. A write strobe stores one byte per acknowledged data byte. The engine keeps the address pointer, so it handles these transfers:
- byte write and page write, which wrap inside a 16-byte page;
- current-address read;
- random read, built from a repeated START after the word address;
- sequential read across the whole space.

A write-protect input stops stores. A busy input, raised by the surrounding logic while it commits a page, keeps the engine fully silent so a master can poll for the end of the write.

Top module: `twm_slave`

## Requirements
- R1: After reset, SDA is released, no memory strobe is active, and the address pointer is 0x000. A current-address read as the first transfer returns the byte at address 0x000.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point abandons the current transfer and begins a new control byte. After a STOP, SDA is released and the engine waits for a START.
- R3: The first byte after a START is received MSB first. It is acknowledged only when its upper four bits equal 1010. Otherwise no acknowledge is given, and every later byte is ignored until the next START.
- R4: The acknowledge pulls SDA low from the SCL falling edge that ends the 8th bit until the SCL falling edge that ends the 9th bit. The pull-low enable changes only while SCL is low.
- R5: In a write control byte, bits 3..1 become address bits 10..8. The acknowledged word-address byte supplies bits 7..0, and this full address is loaded into the pointer. A following data byte is stored at that address.
- R6: During a write, each acknowledged data byte advances only pointer bits 3..0, wrapping inside the 16-byte page. Bits 10..4 do not change.
- R7: While write protect is high, control, address and data bytes are still acknowledged and the pointer still advances, but no write strobe is issued. With write protect low, each acknowledged data byte gives exactly one write strobe.
- R8: While busy is high, no byte is acknowledged, including the control byte. No write strobe is issued and the pointer keeps its value.
- R9: A read control byte (bit 0 = 1) returns the byte at the current pointer, that is, the last accessed address plus one. The block-select bits of a read control byte have no effect.
- R10: A START or STOP that follows the word-address acknowledge stores no data, but the pointer keeps the loaded address. A following read therefore returns that address.
- R11: In a read, a master acknowledge (SDA low on the 9th pulse) makes the engine send the next byte. The pointer increments after each byte is fetched and wraps from 0x7FF to 0x000.
- R12: When the master does not acknowledge a read byte, SDA stays released for all further SCL pulses until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wp_i | input | 1 | Write protect: 1 suppresses memory writes |
| busy_i | input | 1 | Internal write in progress: 1 silences the engine |
| mem_addr_o | output | 11 | Memory address (the address pointer) |
| mem_rd_o | output | 1 | Read strobe; data expected on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write strobe for mem_wdata_o at mem_addr_o |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_rdata_i | input | 8 | Read data from memory |

## Verification
A bit counter that is off by one shows up in the same byte: the acknowledge moves to the wrong SCL pulse, and the master then reads a NACK or a corrupted bit. A pointer with the wrong value, or one that wraps at the wrong width, shows up later, at the first read byte that follows. This is why every write and every wrap is read back, both through current-address reads and through sequential reads. Gating mistakes are seen no later than the ninth pulse of the byte they affect. Examples are a missed busy check, a missed write-protect check, or ignoring a foreign control code. Such a mistake appears as a stray acknowledge on that pulse, or as an unexpected write strobe counted at the memory port.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_WADDR,
    S_WDATA,
    S_READ
  } twm_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twm_line_events.sv
module twm_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL stays high are bus conditions (R2)
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/twm_addr_ptr.sv
module twm_addr_ptr #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              page_inc_i,
  input  logic              seq_inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] SEQ_ONE  = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (page_inc_i) begin
      ptr_d = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_ONE};
    end else if (seq_inc_i) begin
      ptr_d = ptr_q + SEQ_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/twm_byte_fsm.sv
module twm_byte_fsm
  import twm_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              busy_i,
  input  logic              wp_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_pull_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              ptr_load_o,
  output logic [ADDR_W-1:0] ptr_val_o,
  output logic              page_inc_o,
  output logic              seq_inc_o
);
  localparam int BLK_W = ADDR_W - 8;

  twm_state_e       st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d, tx_q, tx_d;
  logic             pull_q, pull_d, rdw_q, rdw_d, pend_q;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             rd_s, wr_s, ld_s, pinc_s;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    pull_d = pull_q;
    rdw_d  = rdw_q;
    blk_d  = blk_q;
    tx_d   = pend_q ? mem_rdata_i : tx_q;
    rd_s   = 1'b0;
    wr_s   = 1'b0;
    ld_s   = 1'b0;
    pinc_s = 1'b0;
    if (stop_i) begin
      st_d   = S_IDLE;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (start_i) begin
      st_d   = S_CTRL;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else if (st_q != S_IDLE && rise_i) begin
      if (cnt_q != 4'd9) cnt_d = cnt_q + 4'd1;
      if (st_q != S_READ && cnt_q < 4'd8) sh_d = {sh_q[6:0], sda_i};
      if (st_q == S_READ && cnt_q == 4'd8) begin
        if (sda_i) st_d = S_IDLE;   // master NACK: go silent
        else       rd_s = 1'b1;     // master ACK: fetch next byte
      end
    end else if (st_q != S_IDLE && fall_i) begin
      if (cnt_q == 4'd8) begin
        case (st_q)
          S_CTRL: begin
            if (sh_q[7:4] == DEV_CODE && !busy_i) begin
              pull_d = 1'b1;
              rdw_d  = sh_q[0];
              blk_d  = sh_q[BLK_W:1];
              rd_s   = sh_q[0];
            end else begin
              st_d = S_IDLE;
            end
          end
          S_WADDR: begin
            if (!busy_i) begin
              pull_d = 1'b1;
              ld_s   = 1'b1;
            end else begin
              st_d = S_IDLE;
            end
          end
          S_WDATA: begin
            if (!busy_i) begin
              pull_d = 1'b1;
              wr_s   = !wp_i;
              pinc_s = 1'b1;
            end else begin
              st_d = S_IDLE;
            end
          end
          default: pull_d = 1'b0;
        endcase
      end else if (cnt_q == 4'd9) begin
        cnt_d = '0;
        case (st_q)
          S_CTRL:  st_d = rdw_q ? S_READ : S_WADDR;
          S_WADDR: st_d = S_WDATA;
          default: st_d = st_q;
        endcase
        pull_d = (st_d == S_READ) ? ~tx_q[7] : 1'b0;
      end else if (st_q == S_READ && cnt_q != 4'd0) begin
        pull_d = ~tx_q[3'(4'd7 - cnt_q)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      pull_q <= 1'b0;
      rdw_q  <= 1'b0;
      blk_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      pull_q <= pull_d;
      rdw_q  <= rdw_d;
      blk_q  <= blk_d;
      pend_q <= rd_s;
    end
  end

  assign sda_pull_o  = pull_q;
  assign mem_rd_o    = rd_s;
  assign mem_wr_o    = wr_s;
  assign mem_wdata_o = sh_q;
  assign ptr_load_o  = ld_s;
  assign ptr_val_o   = {blk_q, sh_q};
  assign page_inc_o  = pinc_s;
  assign seq_inc_o   = pend_q;
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic              start_w, stop_w, rise_w, fall_w;
  logic              ld_w, pinc_w, sinc_w;
  logic [ADDR_W-1:0] ldval_w;

  twm_line_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  twm_byte_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .sda_i       (sda_i),
    .busy_i      (busy_i),
    .wp_i        (wp_i),
    .mem_rdata_i (mem_rdata_i),
    .sda_pull_o  (sda_pull_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .ptr_load_o  (ld_w),
    .ptr_val_o   (ldval_w),
    .page_inc_o  (pinc_w),
    .seq_inc_o   (sinc_w)
  );

  twm_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_w),
    .load_val_i (ldval_w),
    .page_inc_i (pinc_w),
    .seq_inc_i  (sinc_w),
    .ptr_o      (mem_addr_o)
  );
endmodule

// File: rtl/twm_slave_sva.sv
module twm_slave_sva #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              wp_i,
  input logic              busy_i,
  input logic              stop_i,
  input logic              sda_pull_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_pull_o);

  a_r4_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  a_r7_no_write_protected: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> !wp_i);

  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> !busy_i);

  a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W])) &&
                 (mem_addr_o[PAGE_W-1:0] == $past(mem_addr_o[PAGE_W-1:0]) + 1'b1));

  a_r11_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> ##1 (mem_addr_o == $past(mem_addr_o, 2) + 1'b1));
endmodule

bind twm_slave twm_slave_sva #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .wp_i       (wp_i),
  .busy_i     (busy_i),
  .stop_i     (stop_w),
  .sda_pull_o (sda_pull_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/twm_slave_tb_top.sv
module twm_slave_tb_top;
  localparam int AW = 11;
  localparam int Q  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0, busy = 1'b0;
  logic          sda_pull, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  wire           sda_bus = m_sda & ~sda_pull;

  twm_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .wp_i(wp), .busy_i(busy),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [2048];
  logic [7:0] gm  [2048];
  int wr_cnt = 0;

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pair observed items with expected items in order
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e, o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk(e.tag, o.val, e.val);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input string tag, input logic [7:0] v, input logic exp_ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    exp_q.push_back('{tag, {7'b0, exp_ack}});
    obs_q.push_back('{tag, {7'b0, ~b}});
  endtask

  task automatic get_byte(input string tag, input logic [7:0] expv, input logic mack);
    logic b;
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); r[i] = b; end
    send_bit(~mack);
    exp_q.push_back('{tag, expv});
    obs_q.push_back('{tag, r});
  endtask

  task automatic set_addr(input logic [AW-1:0] a);
    bus_start();
    put_byte("R5 write ctrl ack", {4'hA, a[10:8], 1'b0}, 1'b1);
    put_byte("R5 word address ack", a[7:0], 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic b;
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'((i * 7) ^ (i >> 3) ^ 8'h5C);
      gm[i]  = mem[i];
    end
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 sda released", {7'b0, sda_pull}, 8'h00);
    chk("R1 no strobes", {6'b0, mem_rd, mem_wr}, 8'h00);

    // R1 R9 first current-address read hits 0x000
    bus_start();
    put_byte("R3 read ctrl ack", 8'hA1, 1'b1);
    get_byte("R1 pointer zero", gm[0], 1'b0);
    bus_stop();
    // R9 block bits ignored on read, pointer = last + 1
    bus_start();
    put_byte("R9 read ctrl ack", 8'hA3, 1'b1);
    get_byte("R9 last plus one", gm[1], 1'b0);
    bus_stop();

    // R4 R5 byte write to 0x53C with acknowledge timing
    bus_start();
    put_byte("R5 ctrl ack", 8'hAA, 1'b1);
    put_byte("R5 waddr ack", 8'h3C, 1'b1);
    for (int i = 7; i >= 0; i--) send_bit(8'h5A >> i);
    chk("R4 ack driven after 8th fall", {7'b0, sda_pull}, 8'h01);
    recv_bit(b);
    chk("R4 data ack seen", {7'b0, ~b}, 8'h01);
    chk("R4 ack released after 9th fall", {7'b0, sda_pull}, 8'h00);
    bus_stop();
    gm[11'h53C] = 8'h5A;

    // R5 R10 random read back
    set_addr(11'h53C);
    bus_start();
    put_byte("R10 read ctrl ack", 8'hA1, 1'b1);
    get_byte("R5 byte stored at block+addr", 8'h5A, 1'b0);
    bus_stop();
    bus_start();
    put_byte("R9 ctrl ack", 8'hA1, 1'b1);
    get_byte("R9 current after random", gm[11'h53D], 1'b0);
    bus_stop();

    // R6 page write wrapping inside 16 bytes
    set_addr(11'h21E);
    put_byte("R6 data ack", 8'h11, 1'b1);
    put_byte("R6 data ack", 8'h22, 1'b1);
    put_byte("R6 data ack", 8'h33, 1'b1);
    put_byte("R6 data ack", 8'h44, 1'b1);
    bus_stop();
    gm[11'h21E] = 8'h11; gm[11'h21F] = 8'h22;
    gm[11'h210] = 8'h33; gm[11'h211] = 8'h44;
    bus_start();
    put_byte("R6 ctrl ack", 8'hA1, 1'b1);
    get_byte("R6 pointer kept in page", gm[11'h212], 1'b0);
    bus_stop();
    set_addr(11'h21E);
    bus_start();
    put_byte("R6 ctrl ack", 8'hA1, 1'b1);
    get_byte("R6 first byte", 8'h11, 1'b1);
    get_byte("R6 second byte", 8'h22, 1'b1);
    get_byte("R6 next page untouched", gm[11'h220], 1'b0);
    bus_stop();
    set_addr(11'h210);
    bus_start();
    put_byte("R6 ctrl ack", 8'hA1, 1'b1);
    get_byte("R6 wrapped byte", 8'h33, 1'b1);
    get_byte("R6 wrapped byte", 8'h44, 1'b0);
    bus_stop();

    // R3 foreign code is ignored
    bus_start();
    put_byte("R3 foreign code no ack", 8'hB0, 1'b0);
    put_byte("R3 later byte ignored", 8'h12, 1'b0);
    bus_stop();

    // R7 write protect
    wp = 1'b1;
    set_addr(11'h110);
    put_byte("R7 protected data ack", 8'hEE, 1'b1);
    put_byte("R7 protected data ack", 8'hEF, 1'b1);
    bus_stop();
    wp = 1'b0;
    bus_start();
    put_byte("R7 ctrl ack", 8'hA1, 1'b1);
    get_byte("R7 pointer advanced", gm[11'h112], 1'b0);
    bus_stop();
    set_addr(11'h110);
    bus_start();
    put_byte("R7 ctrl ack", 8'hA1, 1'b1);
    get_byte("R7 not stored", gm[11'h110], 1'b0);
    bus_stop();

    // R8 busy silences everything
    busy = 1'b1;
    bus_start();
    put_byte("R8 write ctrl no ack", 8'hA0, 1'b0);
    bus_stop();
    bus_start();
    put_byte("R8 read ctrl no ack", 8'hA1, 1'b0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte("R8 ctrl ack after busy", 8'hA0, 1'b1);
    busy = 1'b1;
    put_byte("R8 waddr no ack", 8'h40, 1'b0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    put_byte("R8 ctrl ack", 8'hA1, 1'b1);
    get_byte("R8 pointer untouched", gm[11'h111], 1'b0);
    bus_stop();

    // R11 sequential read wraps 0x7FF -> 0x000, R12 silence after NACK
    set_addr(11'h7FE);
    bus_start();
    put_byte("R11 ctrl ack", 8'hA1, 1'b1);
    get_byte("R11 seq byte", gm[11'h7FE], 1'b1);
    get_byte("R11 seq byte", gm[11'h7FF], 1'b1);
    get_byte("R11 wrap to zero", gm[0], 1'b1);
    get_byte("R11 after wrap", gm[1], 1'b0);
    get_byte("R12 released after nack", 8'hFF, 1'b0);
    bus_stop();

    // R2 START mid-byte restarts control reception
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    put_byte("R2 restart ctrl ack", 8'hA0, 1'b1);
    put_byte("R2 waddr ack", 8'h05, 1'b1);
    put_byte("R2 data ack", 8'h77, 1'b1);
    bus_stop();
    gm[5] = 8'h77;
    set_addr(11'h005);
    bus_start();
    put_byte("R2 ctrl ack", 8'hA1, 1'b1);
    get_byte("R2 restarted write stored", 8'h77, 1'b0);
    bus_stop();

    // R10 STOP after word address stores nothing, pointer kept
    set_addr(11'h006);
    bus_stop();
    bus_start();
    put_byte("R10 ctrl ack", 8'hA1, 1'b1);
    get_byte("R10 pointer loaded no store", gm[6], 1'b0);
    bus_stop();

    tick(10);
    chk("R7 write strobe count", 8'(wr_cnt), 8'd6);
    chk("R2 released at idle", {7'b0, sda_pull}, 8'h00);
    while (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s: actual=missing expected=%h", e.tag, e.val);
    end
    summary();
    $finish;
  end
endmodule